// File: doc/BRIEF.md
# Gather Element Address Generator

This unit forms the byte address of one element of a halfword gather. It adds a 64-bit scalar base to an offset taken from one element of an index vector. A per-instruction mode controls how that offset is formed. The offset is either the low 32 bits of the element or the whole 64-bit element. A 32-bit offset is widened by zero fill or by sign fill. The widened offset is then optionally doubled, so that the index counts halfwords instead of bytes.

Two element layouts exist. With 32-bit elements only 32-bit offsets are meaningful. With 64-bit (unpacked) elements both offset widths are allowed. The sum is registered: each accepted element produces one address one clock later, together with a valid strobe. Memory access and element sequencing are handled elsewhere.

Top module: `gather_addr_gen`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge (one-cycle latency). It is low during reset and in the first cycle after reset.
- R2: When `in_valid` is sampled high, `addr_o` on the next cycle equals `base_i + (offset << scale_i)` for the offset defined in R3 to R6.
- R3: Narrow offset with `sext_i`=0: the offset is bits [31:0] of `elem_i`, with bits [63:32] of the offset forced to zero.
- R4: Narrow offset with `sext_i`=1: the offset is bits [31:0] of `elem_i`, with bit 31 copied into bits [63:32] of the offset.
- R5: When `elem_wide_i`=1 and `off_wide_i`=1, the offset is all 64 bits of `elem_i`, treated as unsigned, and `sext_i` has no effect.
- R6: When `elem_wide_i`=0 (32-bit element layout), the offset is always narrow. `off_wide_i` and `elem_i[63:32]` have no effect on the address.
- R7: `scale_i`=1 shifts the offset left by one bit before the add. Offset bit 63 is discarded, and address bit 0 equals base bit 0.
- R8: The addition wraps modulo 2^64, and no carry is reported.
- R9: Synchronous active-low reset clears `out_valid` and `addr_o` to zero.
- R10: When `in_valid` is sampled low, `addr_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An element is presented this cycle |
| base_i | input | 64 | Scalar base address |
| elem_i | input | 64 | Index vector element; only [31:0] is meaningful in the 32-bit layout |
| elem_wide_i | input | 1 | 1 = 64-bit element layout, 0 = 32-bit element layout |
| off_wide_i | input | 1 | 1 = full 64-bit offset (honoured only in the 64-bit layout) |
| sext_i | input | 1 | 1 = sign-fill a narrow offset, 0 = zero-fill |
| scale_i | input | 1 | 1 = double the offset before the add |
| out_valid | output | 1 | `addr_o` holds a new address |
| addr_o | output | 64 | Computed element address |

## Verification
The hardest corners to reach are the ones where an ignored input could still leak into the sum. Examples are a 32-bit layout with `off_wide_i` set and garbage in the upper element half, or a full-width offset whose bit 31 is set while `sext_i` is high. Random values almost never isolate these cases. Directed vectors therefore place all-ones patterns in exactly the bits that must be ignored, so that any leak shifts the address by a large amount. Further directed vectors put offset bit 63 under scaling and use a base near the top of the address space, which exercises the discarded shift bit and the wrap-around carry. A long random run covering every mode combination follows these directed vectors.

// File: rtl/gag_pkg.sv
// Package: shared widths and the resolved mode type for the gather address generator.
// Assumes: address and element widths are equal; the narrow offset is narrower than both.
package gag_pkg;
    localparam int unsigned GAG_ADDR_W   = 64;
    localparam int unsigned GAG_NARROW_W = 32;

    // Mode after the layout rules have been applied.
    typedef struct packed {
        logic use_wide;   // take the whole element as an unsigned offset
        logic use_sext;   // sign-fill the narrow offset
        logic dbl;        // shift offset left by one
    } gag_mode_t;
endpackage

// File: rtl/gag_mode_resolve.sv
// Module: folds the raw instruction mode bits into the effective mode.
// Assumes: a 32-bit element layout can only carry a narrow offset, and a
// full-width offset is never sign-filled.
module gag_mode_resolve
    import gag_pkg::*;
(
    input  logic      elem_wide_i,
    input  logic      off_wide_i,
    input  logic      sext_i,
    input  logic      scale_i,
    output gag_mode_t mode_o
);
    // Apply the layout restrictions to the requested offset form.
    always_comb begin
        mode_o.use_wide = elem_wide_i & off_wide_i;
        mode_o.use_sext = ~(elem_wide_i & off_wide_i) & sext_i;
        mode_o.dbl      = scale_i;
    end

    // A full-width offset must never be sign-filled.
    always_comb begin
        if (mode_o.use_wide) begin
            assert (!mode_o.use_sext) else $error("AST_WIDE_UNSIGNED"); // R5
        end
    end
endmodule

// File: rtl/gag_offset_extend.sv
// Module: picks the offset field out of an index element and widens it.
// Assumes: NARROW_W < ELEM_W; the upper element bits are don't-care when narrow.
module gag_offset_extend #(
    parameter int unsigned ELEM_W   = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic [ELEM_W-1:0] elem_i,
    input  logic              use_wide_i,
    input  logic              use_sext_i,
    output logic [ELEM_W-1:0] off_o
);
    localparam int unsigned FILL_W = ELEM_W - NARROW_W;

    logic [NARROW_W-1:0] narrow;
    logic [FILL_W-1:0]   fill;

    // Build the fill bits for the narrow form from the chosen extension.
    always_comb begin
        narrow = elem_i[NARROW_W-1:0];
        fill   = {FILL_W{use_sext_i & narrow[NARROW_W-1]}};
    end

    // Choose between the whole element and the widened narrow field.
    always_comb begin
        off_o = use_wide_i ? elem_i : {fill, narrow};
    end
endmodule

// File: rtl/gag_scale_add.sv
// Module: optional one-bit left shift of the offset followed by a wrapping add.
// Assumes: offset and base share a width; the carry out of the top bit is dropped.
module gag_scale_add #(
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] off_i,
    input  logic              dbl_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] scaled;

    // Halfword scaling: drop the top bit and insert a zero at the bottom.
    always_comb begin
        scaled = dbl_i ? {off_i[ADDR_W-2:0], 1'b0} : off_i;
    end

    // Modulo-2^ADDR_W sum of base and scaled offset.
    always_comb begin
        sum_o = base_i + scaled;
    end
endmodule

// File: rtl/gather_addr_gen.sv
// Module: top of the gather element address generator. Resolves the mode,
// widens the offset, scales and adds it to the base, and registers the result.
// Assumes: one element per cycle, no back-pressure; addr_o holds when idle.
module gather_addr_gen
    import gag_pkg::*;
#(
    parameter int unsigned ADDR_W   = GAG_ADDR_W,
    parameter int unsigned NARROW_W = GAG_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] elem_i,
    input  logic              elem_wide_i,
    input  logic              off_wide_i,
    input  logic              sext_i,
    input  logic              scale_i,
    output logic              out_valid,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] NARROW_SPAN = ADDR_W'(1) << (NARROW_W + 1);

    gag_mode_t         mode;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] sum;

    gag_mode_resolve u_mode (
        .elem_wide_i (elem_wide_i),
        .off_wide_i  (off_wide_i),
        .sext_i      (sext_i),
        .scale_i     (scale_i),
        .mode_o      (mode)
    );

    gag_offset_extend #(
        .ELEM_W   (ADDR_W),
        .NARROW_W (NARROW_W)
    ) u_ext (
        .elem_i     (elem_i),
        .use_wide_i (mode.use_wide),
        .use_sext_i (mode.use_sext),
        .off_o      (off_ext)
    );

    gag_scale_add #(
        .ADDR_W (ADDR_W)
    ) u_add (
        .base_i (base_i),
        .off_i  (off_ext),
        .dbl_i  (mode.dbl),
        .sum_o  (sum)
    );

    // Output stage: capture the address on a valid element, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr_o    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                addr_o <= sum;
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(addr_o)); // R10
    AST_SCALE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scale_i) |=> (addr_o[0] == $past(base_i[0]))); // R7
    AST_ZEXT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(elem_wide_i && off_wide_i) && !sext_i)
        |=> ((addr_o - $past(base_i)) < NARROW_SPAN)); // R3
    AST_SEXT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(elem_wide_i && off_wide_i) && sext_i && elem_i[NARROW_W-1])
        |=> ((addr_o - $past(base_i)) >= (~NARROW_SPAN + ADDR_W'(1)))); // R4
endmodule

// File: tb/gather_addr_gen_tb_top.sv
// Bench: behavioural reference compared with the outputs on every clock.
module gather_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] base_i = '0;
    logic [63:0] elem_i = '0;
    logic        elem_wide_i = 1'b0;
    logic        off_wide_i = 1'b0;
    logic        sext_i = 1'b0;
    logic        scale_i = 1'b0;
    logic        out_valid;
    logic [63:0] addr_o;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_addr = '0;
    string       exp_tag = "R9";
    logic [63:0] lcg = 64'h1234_5678_9abc_def1;

    always #4 clk = ~clk;

    gather_addr_gen dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .base_i (base_i), .elem_i (elem_i), .elem_wide_i (elem_wide_i),
        .off_wide_i (off_wide_i), .sext_i (sext_i), .scale_i (scale_i),
        .out_valid (out_valid), .addr_o (addr_o)
    );

    // Reference: arithmetic on integers, written from the requirements.
    function automatic logic [63:0] model(input logic [63:0] b, input logic [63:0] e,
                                          input logic ew, input logic ow,
                                          input logic sx, input logic sc);
        longint off;
        if (ew && ow)
            off = longint'(e);                       // R5
        else if (sx)
            off = longint'($signed(e[31:0]));        // R4
        else
            off = longint'({32'h0, e[31:0]});        // R3, R6
        if (sc) off = off * 2;                       // R7
        return 64'(longint'(b) + off);               // R8
    endfunction

    task automatic compare();
        n_cmp++;
        if (out_valid !== exp_valid || addr_o !== exp_addr) begin
            n_bad++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                     exp_tag, out_valid, addr_o, exp_valid, exp_addr);
        end
    endtask

    // One clock: check the previous cycle's result, then apply new stimulus.
    task automatic step(input logic v, input logic [63:0] b, input logic [63:0] e,
                        input logic ew, input logic ow, input logic sx,
                        input logic sc, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; base_i = b; elem_i = e;
        elem_wide_i = ew; off_wide_i = ow; sext_i = sx; scale_i = sc;
        exp_valid = v;                                // R1
        if (v) exp_addr = model(b, e, ew, ow, sx, sc); // R2; else hold, R10
        exp_tag = tag;
    endtask

    function automatic logic [63:0] rnd();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg ^ (lcg >> 29);
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        exp_tag = "R9";
        compare();                                    // reset state, R9
        rst_n = 1'b1;
        step(1'b0, '0, '0, 0, 0, 0, 0, "R9");
        // R3: upper element bits set, zero fill of narrow field
        step(1, 64'h0000_1000_0000_0000, 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 0, "R3");
        // R4: same field sign-filled
        step(1, 64'h0000_1000_0000_0000, 64'hFFFF_FFFF_8000_0000, 1, 0, 1, 0, "R4");
        // R4: positive narrow value with sign fill
        step(1, 64'h0000_0000_0000_0100, 64'h0000_0000_7FFF_FFFF, 0, 0, 1, 1, "R4");
        // R5: wide offset, sext ignored even with bit 31 set
        step(1, 64'h10, 64'h0000_0001_8000_0000, 1, 1, 1, 0, "R5");
        // R6: 32-bit layout ignores off_wide and upper element bits
        step(1, 64'h2000, 64'hDEAD_BEEF_0000_0040, 0, 1, 0, 0, "R6");
        step(1, 64'h2000, 64'hDEAD_BEEF_FFFF_FFFE, 0, 1, 1, 1, "R6");
        // R7: scaling drops offset bit 63
        step(1, 64'h1, 64'h8000_0000_0000_0003, 1, 1, 0, 1, "R7");
        // R8: wrap past the top of the address space
        step(1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 1, 1, 0, 0, "R8");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF, 0, 0, 0, 1, "R8");
        // R10: idle cycles hold the last address while inputs move
        step(0, 64'h5555, 64'h7777, 1, 1, 0, 1, "R10");
        step(0, 64'hAAAA, 64'h1, 0, 0, 1, 0, "R10");
        // R1: back-to-back and alternating valid
        step(1, 64'h100, 64'h4, 1, 0, 0, 1, "R1");
        step(0, 64'h0, 64'h0, 0, 0, 0, 0, "R1");
        step(1, 64'h200, 64'h8, 0, 0, 0, 0, "R1");
        // R2: random modes, operands and valid pattern
        for (int i = 0; i < 400; i++) begin
            logic [63:0] m;
            m = rnd();
            step(m[0] | m[1], rnd(), rnd(), m[2], m[3], m[4], m[5], "R2");
        end
        // R9: reset in mid-stream clears outputs
        @(negedge clk);
        compare();
        rst_n = 1'b0; in_valid = 1'b1;
        exp_valid = 1'b0; exp_addr = '0; exp_tag = "R9";
        step(1, 64'h9, 64'h9, 1, 1, 0, 0, "R9");
        rst_n = 1'b1;
        exp_valid = 1'b1; exp_addr = 64'h12; exp_tag = "R2";
        step(0, '0, '0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        compare();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule